// File: doc/BRIEF.md
# Packet FIFO with Mark and Rewind

This block stores 32-bit words in first-in, first-out order for packet traffic, and it can keep one packet so that it can be sent again. A producer pushes words and a consumer pops them; the oldest stored word is always visible on the pop data port while the FIFO holds data. Pulsing `mark` records the current read position. Pulsing `restore` moves the read position back to that record, so the packet is read again. Pulsing `mark_free` drops the record and hands the kept words back as free space. While a record is held, every word from the recorded position up to the write position counts as occupied.

A small register port gives software a status word and a flush command. An elaboration parameter picks the flavour. A read-type instance reports how many words are stored, plus empty and one-word-left flags. A write-type instance reports how many slots are free, plus full and one-slot-left flags. If a packet larger than the whole store is written while its start is still recorded, the FIFO ends up full and empty at once. It cannot move in that state. A sticky error flag and an interrupt output then stay asserted until software writes the flush code.

Top module: `pkt_fifo_mr`

## Requirements
- R1: After a synchronous active-low reset the FIFO is empty, no position is recorded, the error flag and `irq_err` are low, and the count field shows 0 (read type) or DEPTH (write type).
- R2: Words leave in the order they were accepted; while at least one word is readable, `pop_data` shows the oldest unread word with no added latency. A push and a pop in the same cycle both take effect.
- R3: A read at byte offset 4 returns the status word. Bits 15:0 hold the occupancy (words pushed and not yet popped) for type 0, or the vacancy (DEPTH minus the words from the recorded position, or from the read position when nothing is recorded, up to the write position) for type 1. Bits 28:16 read as zero.
- R4: Status bit 31 is set when the FIFO holds no readable word (type 0) or when the occupied span equals DEPTH (type 1). Bit 30 is set when exactly one word is readable (type 0) or when exactly one slot is free (type 1).
- R5: `restore` while a position is recorded sets the read position back to the recorded one, so the same words are popped again.
- R6: While a position is recorded, words between it and the write position stay occupied, so pushes stop when that span reaches DEPTH. `mark_free` gives the span back.
- R7: When the occupied span equals DEPTH and no word is readable, status bit 29 and `irq_err` rise on the next cycle. They stay high through any push, pop or restore until a flush or a reset.
- R8: A write of 0x0000000A at byte offset 0 empties the FIFO, drops the recorded position and clears the error by the next cycle. Any other value at offset 0, and any write at offset 4, has no effect.
- R9: A read at byte offset 0 returns an identity word: bits 15:0 hold DEPTH, bit 16 holds the type (0 read, 1 write), all other bits are zero.
- R10: A push when the occupied span equals DEPTH, and a pop when no word is readable, are ignored and leave the stored data and positions unchanged.
- R11: In one cycle, `restore` with a recorded position overrides a pop, `mark` records the read position as it was before that cycle's pop, and `mark` wins over `mark_free`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Write one word this cycle |
| push_data | input | DATA_W | Word to write |
| pop | input | 1 | Consume the oldest readable word |
| pop_data | output | DATA_W | Oldest readable word |
| mark | input | 1 | Record the current read position |
| restore | input | 1 | Rewind the read position to the record |
| mark_free | input | 1 | Drop the record and free its words |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset (0 or 4) |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for `reg_addr` |
| irq_err | output | 1 | Error interrupt, high while the error flag is set |

## Verification
On every cycle the assertions check that the occupied span never exceeds DEPTH, that a refused pop leaves the read position still, and that a rewind lands exactly on the recorded position. They also check that the error flag holds until a flush, that a flush empties the FIFO, and that the unused status bits stay zero. Only the bench scenarios can show the rest: replayed packets carry the same data in order, the count and flag encodings differ between the two types, a near-miss command value does not flush, and the same-cycle combinations of rewind, record, pop and free resolve as required. The bench reaches these through a behavioural queue model that drives two instances, one of each type.

// File: rtl/pfm_pkg.sv
// Shared constants and the status word layout of the packet FIFO.
// Assumes a 32-bit register port addressed by byte offset.
package pfm_pkg;
    localparam int unsigned KIND_READ  = 0;
    localparam int unsigned KIND_WRITE = 1;

    localparam logic [2:0]  OFS_CTRL   = 3'd0;
    localparam logic [2:0]  OFS_STAT   = 3'd4;
    localparam logic [31:0] FLUSH_CODE = 32'h0000_000A;

    typedef struct packed {
        logic        edge_flag;   // empty (read type) or full (write type)
        logic        near_flag;   // one word left / one slot left
        logic        lock_flag;   // sticky full-and-empty error
        logic [12:0] zero_bits;
        logic [15:0] count;
    } stat_word_t;
endpackage

// File: rtl/pfm_store.sv
// Word storage of the packet FIFO: one write port, one asynchronous read port.
// Assumes DEPTH is a power of two; the caller guards writes against overflow.
module pfm_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Store the pushed word at the write slot.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Present the word at the read slot without latency.
    assign rdata = cells[raddr];
endmodule

// File: rtl/pfm_ptrs.sv
// Read, write and recorded positions of the packet FIFO with the span logic.
// Positions carry one extra bit so that a full span differs from an empty one.
// Assumes restore overrides pop, and mark overrides mark_free, in one cycle.
module pfm_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic          mark,
    input  logic          restore,
    input  logic          mark_free,
    output logic          push_ok,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] mark_ptr,
    output logic          mark_vld,
    output logic [PW-1:0] occ,
    output logic [PW-1:0] used,
    output logic          full,
    output logic          empty
);
    logic [PW-1:0] wr_q, rd_q, mk_q;
    logic          mk_vld_q;
    logic [PW-1:0] base;
    logic          rewind;
    logic          pop_ok;

    // Derive readable words and occupied span from the positions.
    always_comb begin
        base   = mk_vld_q ? mk_q : rd_q;
        occ    = wr_q - rd_q;
        used   = wr_q - base;
        full   = (used == PW'(DEPTH));
        empty  = (occ == '0);
        rewind = restore && mk_vld_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty && !rewind;
    end

    // Advance the write position on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q <= '0;
        end else if (push_ok) begin
            wr_q <= wr_q + 1'b1;
        end
    end

    // Move the read position: rewind first, otherwise an accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q <= '0;
        end else if (rewind) begin
            rd_q <= mk_q;
        end else if (pop_ok) begin
            rd_q <= rd_q + 1'b1;
        end
    end

    // Record or drop the packet start position.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            mk_q     <= '0;
            mk_vld_q <= 1'b0;
        end else if (mark) begin
            mk_q     <= rd_q;
            mk_vld_q <= 1'b1;
        end else if (mark_free) begin
            mk_vld_q <= 1'b0;
        end
    end

    assign wr_ptr   = wr_q;
    assign rd_ptr   = rd_q;
    assign mark_ptr = mk_q;
    assign mark_vld = mk_vld_q;
endmodule

// File: rtl/pfm_status.sv
// Status word builder and sticky error latch of the packet FIFO.
// KIND selects read-type (occupancy) or write-type (vacancy) reporting.
// Assumes DEPTH fits the 16-bit count field.
module pfm_status
    import pfm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int KIND  = 0,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [PW-1:0] occ,
    input  logic [PW-1:0] used,
    input  logic          full,
    input  logic          empty,
    output logic          lock_q,
    output stat_word_t    stat
);
    // Latch the full-and-empty error until a flush or a reset.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            lock_q <= 1'b0;
        end else if (full && empty) begin
            lock_q <= 1'b1;
        end
    end

    generate
        if (KIND == KIND_READ) begin : g_read_kind
            // Report readable words and the empty side flags.
            always_comb begin
                stat           = '0;
                stat.edge_flag = empty;
                stat.near_flag = (occ == PW'(1));
                stat.lock_flag = lock_q;
                stat.count     = 16'(occ);
            end
        end else begin : g_write_kind
            logic [PW-1:0] vac;
            assign vac = PW'(DEPTH) - used;
            // Report free slots and the full side flags.
            always_comb begin
                stat           = '0;
                stat.edge_flag = full;
                stat.near_flag = (vac == PW'(1));
                stat.lock_flag = lock_q;
                stat.count     = 16'(vac);
            end
        end
    endgenerate
endmodule

// File: rtl/pfm_regs.sv
// Register decode of the packet FIFO: flush command and read-back mux.
// Assumes byte offsets 0 (control/identity) and 4 (status); others read zero.
module pfm_regs
    import pfm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int KIND  = 0
) (
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  stat_word_t  stat,
    output logic        flush,
    output logic [31:0] reg_rdata
);
    localparam logic [31:0] IDENT = {15'd0, 1'(KIND), 16'(DEPTH)};

    // Recognise the flush command only at the control offset.
    assign flush = reg_we && (reg_addr == OFS_CTRL) && (reg_wdata == FLUSH_CODE);

    // Select the identity or the status word for reading.
    always_comb begin
        case (reg_addr)
            OFS_CTRL: reg_rdata = IDENT;
            OFS_STAT: reg_rdata = stat;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pkt_fifo_mr.sv
// Packet FIFO with mark/rewind: storage, positions, status and register port.
// Assumes DEPTH is a power of two up to 32768 and KIND is 0 (read) or 1 (write).
module pkt_fifo_mr
    import pfm_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int KIND   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              mark,
    input  logic              restore,
    input  logic              mark_free,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          flush;
    logic          push_ok;
    logic [PW-1:0] wr_ptr, rd_ptr, mark_ptr, occ, used;
    logic          mark_vld, full, empty, dl_q;
    stat_word_t    stat;

    pfm_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push), .pop(pop), .mark(mark), .restore(restore), .mark_free(mark_free),
        .push_ok(push_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .mark_ptr(mark_ptr),
        .mark_vld(mark_vld), .occ(occ), .used(used), .full(full), .empty(empty)
    );

    pfm_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(push_ok), .waddr(wr_ptr[AW-1:0]), .wdata(push_data),
        .raddr(rd_ptr[AW-1:0]), .rdata(pop_data)
    );

    pfm_status #(.DEPTH(DEPTH), .KIND(KIND)) u_status (
        .clk(clk), .rst_n(rst_n), .flush(flush), .occ(occ), .used(used),
        .full(full), .empty(empty), .lock_q(dl_q), .stat(stat)
    );

    pfm_regs #(.DEPTH(DEPTH), .KIND(KIND)) u_regs (
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .stat(stat), .flush(flush), .reg_rdata(reg_rdata)
    );

    assign irq_err = dl_q;
endmodule

// File: rtl/pfm_checker.sv
// Property checker for the packet FIFO, bound into every pkt_fifo_mr instance.
module pfm_checker #(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          pop,
    input logic          restore,
    input logic          mark_vld,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] mark_ptr,
    input logic [PW-1:0] occ,
    input logic [PW-1:0] used,
    input logic          dl,
    input logic          irq,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_rdata
);
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (occ == '0) && !dl && !mark_vld);

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4) |-> (reg_rdata[28:16] == 13'd0));

    assert_rewind_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && mark_vld && !flush) |=> (rd_ptr == $past(mark_ptr)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PW'(DEPTH));

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dl && !flush) |=> dl);

    assert_irq_matches_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4) |-> (reg_rdata[29] == irq));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0) && !dl && !mark_vld);

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (occ == '0) && !(restore && mark_vld) && !flush) |=> $stable(rd_ptr));
endmodule

bind pkt_fifo_mr pfm_checker #(.DEPTH(DEPTH)) u_pfm_checker (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pop(pop), .restore(restore),
    .mark_vld(mark_vld), .rd_ptr(rd_ptr), .mark_ptr(mark_ptr), .occ(occ),
    .used(used), .dl(dl_q), .irq(irq_err), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_pkt_fifo_mr.sv
`timescale 1ns/1ps
// Bench: one read-type and one write-type instance share stimulus; a
// behavioural model (integer positions, word array) is compared every cycle.
module test_pkt_fifo_mr;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 0, pop = 0, mark = 0, restore = 0, mark_free = 0;
    logic [31:0] push_data = '0;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = 3'd4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] pop_data_r, pop_data_w, rdata_r, rdata_w;
    logic        irq_r, irq_w;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] next_val = 32'h1000_0000;

    always #10 clk = ~clk;

    pkt_fifo_mr #(.DEPTH(DEPTH), .KIND(0)) i_pkt_fifo_mr (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data_r), .mark(mark), .restore(restore), .mark_free(mark_free),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_r), .irq_err(irq_r));

    pkt_fifo_mr #(.DEPTH(DEPTH), .KIND(1)) i_pkt_fifo_mr_w (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data_w), .mark(mark), .restore(restore), .mark_free(mark_free),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_w), .irq_err(irq_w));

    // Reference model state
    logic [31:0] m_mem [DEPTH];
    int  m_wr = 0, m_rd = 0, m_mk = 0;
    bit  m_mv = 0, m_dl = 0;

    always @(posedge clk) begin
        int occ, used, old_rd;
        bit f, e;
        if (!rst_n || (reg_we && reg_addr == 3'd0 && reg_wdata == 32'h0000_000A)) begin
            m_wr = 0; m_rd = 0; m_mk = 0; m_mv = 0; m_dl = 0;
        end else begin
            occ  = m_wr - m_rd;
            used = m_wr - (m_mv ? m_mk : m_rd);
            f = (used == DEPTH);
            e = (occ == 0);
            old_rd = m_rd;
            if (f && e) m_dl = 1;
            if (push && !f) begin
                m_mem[m_wr % DEPTH] = push_data;
                m_wr++;
            end
            if (restore && m_mv) m_rd = m_mk;
            else if (pop && !e) m_rd++;
            if (mark) begin m_mk = old_rd; m_mv = 1; end
            else if (mark_free) m_mv = 0;
        end
    end

    function automatic logic [31:0] exp_stat(input bit wk);
        int occ, used, vac;
        occ  = m_wr - m_rd;
        used = m_wr - (m_mv ? m_mk : m_rd);
        vac  = DEPTH - used;
        if (!wk) return {occ == 0, occ == 1, m_dl, 13'd0, 16'(occ)};
        return {used == DEPTH, vac == 1, m_dl, 13'd0, 16'(vac)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock, then compare every output with the model away from the edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (reg_addr == 3'd4) begin
            chk("R3 R4 R7 status read-type", rdata_r, exp_stat(0));
            chk("R3 R4 R7 status write-type", rdata_w, exp_stat(1));
        end
        chk("R7 irq read-type", 32'(irq_r), 32'(m_dl));
        chk("R7 irq write-type", 32'(irq_w), 32'(m_dl));
        if (m_wr != m_rd) begin
            chk("R2 head word read-type", pop_data_r, m_mem[m_rd % DEPTH]);
            chk("R2 head word write-type", pop_data_w, m_mem[m_rd % DEPTH]);
        end
    endtask

    task automatic step(input bit pu, input bit po, input bit mk, input bit rs, input bit fr);
        push = pu; pop = po; mark = mk; restore = rs; mark_free = fr;
        push_data = next_val;
        if (pu) next_val = next_val + 32'h11;
        tick();
        push = 0; pop = 0; mark = 0; restore = 0; mark_free = 0;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] v);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        tick();
        reg_we = 0; reg_addr = 3'd4; reg_wdata = '0;
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] first;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state for both types
        chk("R1 reset status read-type", rdata_r, 32'h8000_0000);
        chk("R1 reset status write-type", rdata_w, 32'h0000_0008);
        chk("R1 reset irq", 32'(irq_r | irq_w), 32'h0);

        // R9: identity word at offset 0
        reg_addr = 3'd0; #1;
        chk("R9 identity read-type", rdata_r, 32'h0000_0008);
        chk("R9 identity write-type", rdata_w, 32'h0001_0008);
        reg_addr = 3'd4;

        // R2: order and simultaneous push/pop
        first = next_val;
        step(1,0,0,0,0); step(1,0,0,0,0); step(1,0,0,0,0);
        chk("R2 oldest word first", pop_data_r, first);
        step(1,1,0,0,0); step(0,1,0,0,0);
        chk("R2 occupancy after mixed traffic", rdata_r, 32'h0000_0002);
        step(0,1,0,0,0); step(0,1,0,0,0);

        // R10: fill, overfill, drain, overdrain
        for (int i = 0; i < DEPTH; i++) step(1,0,0,0,0);
        chk("R4 full flag write-type", rdata_w, 32'h8000_0000);
        step(1,0,0,0,0);
        chk("R10 push when full ignored read-type", rdata_r, 32'h0000_0008);
        chk("R10 push when full ignored write-type", rdata_w, 32'h8000_0000);
        for (int i = 0; i < DEPTH - 1; i++) step(0,1,0,0,0);
        chk("R4 one word left read-type", rdata_r, 32'h4000_0001);
        chk("R4 one slot left write-type", rdata_w, 32'h0000_0007);
        step(0,1,0,0,0); step(0,1,0,0,0);
        chk("R10 pop when empty ignored", rdata_r, 32'h8000_0000);

        // R5/R6: mark, consume, rewind, release
        first = next_val;
        for (int i = 0; i < 4; i++) step(1,0,0,0,0);
        step(0,0,1,0,0);
        step(0,1,0,0,0); step(0,1,0,0,0); step(0,1,0,0,0);
        step(0,0,0,1,0);
        chk("R5 rewind head word", pop_data_r, first);
        chk("R5 rewind occupancy", rdata_r, 32'h0000_0004);
        for (int i = 0; i < 4; i++) step(0,1,0,0,0);
        chk("R6 held span still occupied", rdata_w, 32'h0000_0004);
        step(0,0,0,0,1);
        chk("R6 release frees span", rdata_w, 32'h0000_0008);

        // R7: oversized packet while marked locks the FIFO
        wreg(3'd0, 32'h0000_000A);
        step(0,0,1,0,0);
        for (int i = 0; i < DEPTH; i++) step(1,0,0,0,0);
        for (int i = 0; i < DEPTH; i++) step(0,1,0,0,0);
        step(0,0,0,0,0);
        chk("R7 lock status read-type", rdata_r, 32'hA000_0000);
        chk("R7 lock status write-type", rdata_w, 32'hA000_0000);
        chk("R7 irq raised", 32'(irq_r), 32'h1);
        step(0,0,0,1,0);
        chk("R7 lock survives rewind", rdata_r, 32'h2000_0008);

        // R8: only the exact code at offset 0 flushes
        wreg(3'd0, 32'h0000_0005);
        chk("R8 wrong code ignored", rdata_r, 32'h2000_0008);
        wreg(3'd4, 32'h0000_000A);
        chk("R8 status offset write ignored", rdata_r, 32'h2000_0008);
        wreg(3'd0, 32'h0000_000A);
        chk("R8 flush empties read-type", rdata_r, 32'h8000_0000);
        chk("R8 flush restores vacancy", rdata_w, 32'h0000_0008);
        chk("R8 flush clears irq", 32'(irq_r), 32'h0);

        // R11: same-cycle combinations
        first = next_val;
        step(1,0,0,0,0); step(1,0,0,0,0); step(1,0,0,0,0);
        step(0,1,1,0,0);
        chk("R11 mark with pop consumes", rdata_r, 32'h0000_0002);
        step(0,1,0,1,0);
        chk("R11 rewind overrides pop", rdata_r, 32'h0000_0003);
        chk("R11 rewind to pre-pop position", pop_data_r, first);
        step(0,0,1,0,1);
        for (int i = 0; i < 3; i++) step(0,1,0,0,0);
        chk("R11 mark wins over release", rdata_w, 32'h0000_0005);
        step(0,0,0,0,1);
        chk("R6 release after replay", rdata_w, 32'h0000_0008);

        finish_run();
    end
endmodule